// File: doc/BRIEF.md
# SPI Register Transaction Engine with Target Wait States

This block runs one register access, read or write, against a SPI target that can hold off the controller while it gets ready. A command port takes the direction, a byte count from 1 to 64 and a 24-bit register address. The engine pulls chip select low and sends a four-byte header. It then waits for the target to signal that it is ready, moves the data bytes and raises chip select again. Done and error pulses report the outcome. Read bytes come out as a strobed stream, and write bytes are pulled in through a ready/valid handshake.

The target signals readiness in the least significant bit of the byte it returns while the last header byte goes out. If that bit is clear, the engine keeps chip select low and clocks dummy bytes one at a time. It stops polling once a returned byte has its low bit set. A cycle-count timeout bounds the polling. When it expires, the engine releases chip select and reports an error with no data phase. A byte-level serial shifter is part of the block. It uses SPI mode 0, sends the most significant bit first, and derives SCLK by dividing the system clock.

Top module: `spi_reg_txn`

## Requirements
- R1: Header byte 0 is {dir, 1, len-1}. Bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 hold the length minus one.
- R2: A command whose length is 0 or greater than MAX_LEN (64) is rejected. Done and error pulse together on the cycle after acceptance, and chip select and SCLK do not move.
- R3: Header bytes 1, 2 and 3 carry address bits 23:16, 15:8 and 7:0, in that order.
- R4: Chip select goes low before the first SCLK rising edge and stays low through the header, any polling and the data phase. SCLK is high only while chip select is low. Done pulses on the same cycle that chip select returns high.
- R5: If bit 0 of the byte received during header byte 3 is 1, the first data byte is the next byte on the bus.
- R6: If that bit is 0, the engine clocks dummy bytes with MOSI held at 0. The data phase begins right after the first polled byte whose bit 0 is 1.
- R7: If no ready bit arrives within TIMEOUT_CYC cycles of polling, the engine finishes the current dummy byte, releases chip select and pulses done and error together. No data bytes move.
- R8: rd_data is all zeros on every cycle where rd_valid is low. An aborted read produces no rd_valid.
- R9: Every byte goes out most significant bit first in mode 0. SCLK idles low, MOSI is set up before each rising edge, and MISO is sampled on the rising edge.
- R10: During a write data phase, each byte taken on a wr_valid/wr_ready handshake appears on MOSI in order. MISO has no effect on the bytes sent or on the outcome.
- R11: During a read data phase, MOSI stays 0. Each received byte is presented once with rd_valid, and rd_last marks the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; a command is accepted on this cycle |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_len | input | 7 | Byte count; legal values 1 to 64 |
| cmd_addr | input | 24 | Target register address |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data byte present |
| wr_ready | output | 1 | Engine takes wr_data on this cycle |
| rd_data | output | 8 | Read data byte; zero when rd_valid is low |
| rd_valid | output | 1 | Read data byte strobe |
| rd_last | output | 1 | Marks the final read byte |
| done | output | 1 | One-cycle pulse when a command finishes |
| error | output | 1 | Qualifies done: rejection or timeout |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bound checker watches, on every cycle, the relationships that hold no matter what the target does. SCLK only pulses inside chip select, chip-select release coincides with done, a done without a chip-select window carries an error, read data is zero outside its strobe, and write handshakes only happen inside a transaction. The bench's target model decodes the header, counts polled bytes and compares data bytes. That comparison is the only way to show the header layout, the exact byte at which the data phase begins after zero or more wait bytes, the mode-0 bit order, and that MISO has no effect on writes. The timeout abort, and the fact that it never reaches a data phase, are shown only by a directed scenario with a target that never becomes ready.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

   localparam int HDR_BYTES = 4;
   localparam int LM_W      = 6;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_POLL = 2'd2,
      ST_DATA = 2'd3
   } txn_state_e;

endpackage

// File: rtl/spi_txn_shifter.sv
module spi_txn_shifter #(
   parameter int DIV_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   output logic       busy,
   output logic       rx_valid,
   output logic [7:0] rx_byte,
   output logic       sclk,
   output logic       mosi,
   input  logic       miso
);

   logic       busy_q;
   logic       sclk_q;
   logic       rxv_q;
   logic [2:0] bit_q;
   logic [7:0] sh_q;
   logic [7:0] rx_q;
   logic       tick;

   generate
      if (DIV_HALF == 1) begin : g_nodiv
         assign tick = busy_q;
      end else begin : g_div
         localparam int CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] DIV_END = CW'(DIV_HALF - 1);
         logic [CW-1:0] div_q;
         assign tick = busy_q && (div_q == DIV_END);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!busy_q || tick) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         rxv_q  <= 1'b0;
         bit_q  <= '0;
         sh_q   <= '0;
         rx_q   <= '0;
      end else begin
         rxv_q <= 1'b0;
         if (start && !busy_q) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            bit_q  <= 3'd7;
            sh_q   <= tx_byte;
         end else if (tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_q   <= {rx_q[6:0], miso};
            end else begin
               sclk_q <= 1'b0;
               if (bit_q == 3'd0) begin
                  busy_q <= 1'b0;
                  rxv_q  <= 1'b1;
               end else begin
                  bit_q <= bit_q - 1'b1;
                  sh_q  <= {sh_q[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign busy     = busy_q;
   assign rx_valid = rxv_q;
   assign rx_byte  = rx_q;
   assign sclk     = sclk_q;
   assign mosi     = busy_q ? sh_q[7] : 1'b0;

endmodule

// File: rtl/spi_txn_hdr.sv
module spi_txn_hdr #(
   parameter int ADDR_W = 24
) (
   input  logic                      rd,
   input  logic [spi_txn_pkg::LM_W-1:0] len_m1,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [1:0]                idx,
   output logic [7:0]                hbyte
);

   logic [7:0] lanes [4];

   assign lanes[0] = {rd, 1'b1, len_m1};

   generate
      for (genvar g = 1; g < 4; g++) begin : g_addr_lane
         assign lanes[g] = addr[(3-g)*8 +: 8];
      end
   endgenerate

   assign hbyte = lanes[idx];

endmodule

// File: rtl/spi_txn_timer.sv
module spi_txn_timer #(
   parameter int LIMIT = 20_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int TW = $clog2(LIMIT + 1);
   localparam logic [TW-1:0] LIM_V = TW'(LIMIT);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q != LIM_V) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = (cnt_q == LIM_V);

endmodule

// File: rtl/spi_reg_txn.sv
module spi_reg_txn #(
   parameter int MAX_LEN     = 64,
   parameter int ADDR_W      = 24,
   parameter int DIV_HALF    = 2,
   parameter int TIMEOUT_CYC = 20_000_000,
   localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_read,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              rd_last,
   output logic              done,
   output logic              error,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);
   import spi_txn_pkg::*;

   generate
      if (MAX_LEN < 1 || MAX_LEN > 64) begin : g_bad_len
         $error("MAX_LEN must lie in 1..64");
      end
      if (ADDR_W != 24) begin : g_bad_addr
         $error("ADDR_W must be 24 for a three-byte address");
      end
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_tmo
         $error("TIMEOUT_CYC must be at least 1");
      end
   endgenerate

   localparam logic [LEN_W-1:0] MAX_LEN_V = LEN_W'(MAX_LEN);

   txn_state_e        st_q;
   logic              rd_q;
   logic [LM_W-1:0]   lm1_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LM_W-1:0]   cnt_q;
   logic              pend_q;
   logic              cs_n_q;
   logic              done_q;
   logic              err_q;
   logic              rdv_q;
   logic              rdl_q;
   logic [7:0]        rdd_q;

   logic              len_ok;
   logic [7:0]        hdr_byte;
   logic [7:0]        sh_tx;
   logic              sh_start;
   logic              sh_busy;
   logic              sh_rxv;
   logic [7:0]        sh_rx;
   logic              tmo;
   logic              can_launch;

   assign len_ok = (cmd_len != '0) && (cmd_len <= MAX_LEN_V);

   spi_txn_hdr #(.ADDR_W(ADDR_W)) u_hdr (
      .rd     (rd_q),
      .len_m1 (lm1_q),
      .addr   (addr_q),
      .idx    (cnt_q[1:0]),
      .hbyte  (hdr_byte)
   );

   spi_txn_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st_q == ST_POLL),
      .expired (tmo)
   );

   spi_txn_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (sh_start),
      .tx_byte  (sh_tx),
      .busy     (sh_busy),
      .rx_valid (sh_rxv),
      .rx_byte  (sh_rx),
      .sclk     (sclk),
      .mosi     (mosi),
      .miso     (miso)
   );

   always_comb begin
      sh_tx      = 8'h00;
      can_launch = 1'b0;
      unique case (st_q)
         ST_HDR: begin
            sh_tx      = hdr_byte;
            can_launch = 1'b1;
         end
         ST_POLL: begin
            can_launch = 1'b1;
         end
         ST_DATA: begin
            sh_tx      = rd_q ? 8'h00 : wr_data;
            can_launch = rd_q || wr_valid;
         end
         default: begin
            can_launch = 1'b0;
         end
      endcase
   end

   assign sh_start  = pend_q && !sh_busy && can_launch;
   assign wr_ready  = (st_q == ST_DATA) && !rd_q && pend_q && !sh_busy;
   assign cmd_ready = (st_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rd_q   <= 1'b0;
         lm1_q  <= '0;
         addr_q <= '0;
         cnt_q  <= '0;
         pend_q <= 1'b0;
         cs_n_q <= 1'b1;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         rdv_q  <= 1'b0;
         rdl_q  <= 1'b0;
         rdd_q  <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         rdv_q  <= 1'b0;
         rdl_q  <= 1'b0;
         rdd_q  <= '0;
         if (sh_start) begin
            pend_q <= 1'b0;
         end
         unique case (st_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  if (!len_ok) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     rd_q   <= cmd_read;
                     lm1_q  <= LM_W'(cmd_len - LEN_W'(1));
                     addr_q <= cmd_addr;
                     cnt_q  <= '0;
                     pend_q <= 1'b1;
                     cs_n_q <= 1'b0;
                     st_q   <= ST_HDR;
                  end
               end
            end
            ST_HDR: begin
               if (sh_rxv) begin
                  pend_q <= 1'b1;
                  if (cnt_q == LM_W'(HDR_BYTES - 1)) begin
                     cnt_q <= '0;
                     st_q  <= sh_rx[0] ? ST_DATA : ST_POLL;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_POLL: begin
               if (sh_rxv) begin
                  if (sh_rx[0]) begin
                     cnt_q  <= '0;
                     pend_q <= 1'b1;
                     st_q   <= ST_DATA;
                  end else if (tmo) begin
                     cs_n_q <= 1'b1;
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else begin
                     pend_q <= 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (sh_rxv) begin
                  if (rd_q) begin
                     rdv_q <= 1'b1;
                     rdd_q <= sh_rx;
                     rdl_q <= (cnt_q == lm1_q);
                  end
                  if (cnt_q == lm1_q) begin
                     cs_n_q <= 1'b1;
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else begin
                     cnt_q  <= cnt_q + 1'b1;
                     pend_q <= 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n     = cs_n_q;
   assign done     = done_q;
   assign error    = err_q;
   assign rd_valid = rdv_q;
   assign rd_last  = rdl_q;
   assign rd_data  = rdd_q;

endmodule

// File: rtl/spi_reg_txn_chk.sv
module spi_reg_txn_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_ready,
   input logic       wr_ready,
   input logic [7:0] rd_data,
   input logic       rd_valid,
   input logic       rd_last,
   input logic       done,
   input logic       error,
   input logic       sclk,
   input logic       mosi,
   input logic       cs_n
);

   // R4 / R9: serial clock pulses only inside a chip-select window
   p_sclk_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);

   // R4: chip-select release is reported by done in the same cycle
   p_release_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> done);

   // R2: a done with no preceding chip-select window is a rejection
   p_reject_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(cs_n)) |-> error);

   // R7: error is only ever a qualifier of done
   p_err_has_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

   // R8: read data is zero outside its strobe
   p_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == 8'h00));

   // R11: last marker only travels with a valid byte
   p_last_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);

   // R10: write bytes are only taken inside a transaction
   p_wr_in_txn_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> (!cs_n && !cmd_ready));

   // R9: bus is quiet while chip select is high
   p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!sclk && !mosi));

endmodule

bind spi_reg_txn spi_reg_txn_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .wr_ready  (wr_ready),
   .rd_data   (rd_data),
   .rd_valid  (rd_valid),
   .rd_last   (rd_last),
   .done      (done),
   .error     (error),
   .sclk      (sclk),
   .mosi      (mosi),
   .cs_n      (cs_n)
);

// File: tb/spi_reg_txn_tb.sv
`timescale 1ns/1ps
module spi_reg_txn_tb;

   localparam int DIVH = 2;
   localparam int TMO  = 400;
   localparam int NV   = 8;

   // entry: {read, len[6:0], addr[23:0], wait[3:0]}
   localparam logic [35:0] VEC [NV] = '{
      {1'b1, 7'd4,  24'h000018, 4'd0},
      {1'b0, 7'd4,  24'h000018, 4'd0},
      {1'b1, 7'd1,  24'hABCDEF, 4'd2},
      {1'b0, 7'd1,  24'h123456, 4'd1},
      {1'b1, 7'd64, 24'hD40024, 4'd3},
      {1'b0, 7'd64, 24'hD40024, 4'd0},
      {1'b1, 7'd2,  24'h800F00, 4'd5},
      {1'b0, 7'd7,  24'h0F0F0F, 4'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_read = 1'b0;
   logic [6:0]  cmd_len = '0;
   logic [23:0] cmd_addr = '0;
   logic [7:0]  wr_data;
   logic        wr_valid = 1'b1;
   logic        wr_ready;
   logic [7:0]  rd_data;
   logic        rd_valid, rd_last, done, error, sclk, mosi, miso, cs_n;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   spi_reg_txn #(.DIV_HALF(DIVH), .TIMEOUT_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_read(cmd_read), .cmd_len(cmd_len), .cmd_addr(cmd_addr),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last),
      .done(done), .error(error), .sclk(sclk), .mosi(mosi), .miso(miso),
      .cs_n(cs_n)
   );

   // ---------------- target model (mode 0, MSB first)
   logic [7:0] tgt_tx [128];
   logic [7:0] tgt_rx [128];
   int         t_byte = 0;
   int         t_bit  = 0;
   logic [7:0] t_sh   = '0;
   int         cs_falls = 0;

   assign miso = cs_n ? 1'b0 : tgt_tx[t_byte[6:0]][3'd7 - t_bit[2:0]];

   always @(negedge cs_n or posedge sclk) begin
      if (sclk && !cs_n) begin
         t_sh = {t_sh[6:0], mosi};
         if (t_bit == 7) begin
            tgt_rx[t_byte[6:0]] = t_sh;
            t_byte = t_byte + 1;
            t_bit  = 0;
         end else begin
            t_bit = t_bit + 1;
         end
      end else if (!sclk) begin
         t_byte   = 0;
         t_bit    = 0;
         cs_falls = cs_falls + 1;
      end
   end

   // ---------------- read stream capture
   logic [7:0] cap   [256];
   logic       cap_l [256];
   int         rd_cnt = 0;
   always @(negedge clk) begin
      if (rd_valid) begin
         cap[rd_cnt[7:0]]   = rd_data;
         cap_l[rd_cnt[7:0]] = rd_last;
         rd_cnt = rd_cnt + 1;
      end
   end

   // ---------------- write data supplier
   logic [7:0] wmem [256];
   int         wr_total = 0;
   int         wr_base  = 0;
   initial begin
      wr_data = 8'h00;
      forever begin
         @(negedge clk);
         wr_data = wmem[(wr_total - wr_base) & 255];
         if (wr_ready && wr_valid) begin
            @(posedge clk);
            #1 wr_total = wr_total + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_done(output bit seen, output bit err);
      int n = 0;
      seen = 1'b0;
      err  = 1'b0;
      while (n < 20000) begin
         @(negedge clk);
         if (done) begin
            seen = 1'b1;
            err  = error;
            break;
         end
         n++;
      end
   endtask

   function automatic logic [7:0] rpat(input int v, input int i);
      return 8'((8'hC3 ^ (i * 3)) + v);
   endfunction

   task automatic run_txn(input int v, input logic rd, input int len,
                          input logic [23:0] addr, input int w);
      int base, rbase, total, first_bad, act_b, exp_b;
      bit seen, err, ok, lst_ok;
      for (int k = 0; k < 128; k++) tgt_tx[k] = 8'hFE;
      for (int k = 0; k < 3; k++) tgt_tx[k] = 8'hA4;
      tgt_tx[3] = (w == 0) ? 8'h41 : 8'h40;
      for (int j = 0; j < w; j++) tgt_tx[4 + j] = (j == w - 1) ? 8'h81 : 8'h80;
      base = 4 + w;
      for (int i = 0; i < len; i++) begin
         tgt_tx[base + i] = rd ? rpat(v, i) : 8'hFF;
         wmem[i] = 8'(8'h3C ^ (i * 5) ^ v);
      end
      rbase   = rd_cnt;
      wr_base = wr_total;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_read = rd; cmd_len = 7'(len); cmd_addr = addr;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done(seen, err);
      check(seen && !err, "R4 done without error", {30'd0, seen, err}, 2);
      @(negedge clk);
      check(cs_n == 1'b1, "R4 chip select released", cs_n, 1);
      total = t_byte;
      check(total == 4 + w + len, "R5/R6 byte count on bus", total, 4 + w + len);
      // R1 header byte 0
      check(tgt_rx[0] == {rd, 1'b1, 6'(len - 1)}, "R1 header byte0",
            tgt_rx[0], {rd, 1'b1, 6'(len - 1)});
      // R3 address bytes, MSB first (also R9 bit order)
      check({tgt_rx[1], tgt_rx[2], tgt_rx[3]} == addr, "R3/R9 header address",
            {tgt_rx[1], tgt_rx[2], tgt_rx[3]}, addr);
      ok = 1'b1;
      for (int j = 0; j < w; j++) if (tgt_rx[4 + j] != 8'h00) ok = 1'b0;
      check(ok, "R6 dummy poll bytes are zero", ok, 1);
      ok = 1'b1; first_bad = 0; act_b = 0; exp_b = 0;
      lst_ok = 1'b1;
      for (int i = 0; i < len; i++) begin
         if (rd) begin
            if (ok && (tgt_rx[base + i] != 8'h00 || cap[(rbase + i) & 255] != rpat(v, i))) begin
               ok = 1'b0; first_bad = i;
               act_b = cap[(rbase + i) & 255]; exp_b = rpat(v, i);
            end
            if (cap_l[(rbase + i) & 255] != (i == len - 1)) lst_ok = 1'b0;
         end else if (ok && tgt_rx[base + i] != wmem[i]) begin
            ok = 1'b0; first_bad = i; act_b = tgt_rx[base + i]; exp_b = wmem[i];
         end
      end
      if (rd) begin
         check(ok, "R11 read bytes and zero MOSI", act_b, exp_b);
         check(lst_ok && (rd_cnt - rbase == len), "R11 rd_valid count and rd_last",
               rd_cnt - rbase, len);
      end else begin
         check(ok, "R10 write bytes on MOSI with MISO ignored", act_b, exp_b);
         check(rd_cnt == rbase, "R10 no read strobes on write", rd_cnt - rbase, 0);
         check(wr_total - wr_base == len, "R10 handshake count", wr_total - wr_base, len);
      end
      if (!ok) $display("  vector %0d first mismatch at byte %0d", v, first_bad);
   endtask

   task automatic reject(input int len);
      int falls0;
      falls0 = cs_falls;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_read = 1'b1; cmd_len = 7'(len); cmd_addr = 24'h000024;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(done && error, "R2 rejected length flagged", {30'd0, done, error}, 3);
      @(negedge clk);
      @(negedge clk);
      check(cs_falls == falls0 && cs_n && !sclk, "R2 no bus activity on reject",
            cs_falls - falls0, 0);
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit seen, err;
      int rb0, tb0;
      for (int k = 0; k < 256; k++) wmem[k] = 8'h00;
      for (int k = 0; k < 128; k++) tgt_tx[k] = 8'h00;
      repeat (4) @(negedge clk);
      check(cs_n && !sclk && !done && cmd_ready && !rd_valid && rd_data == 8'h00,
            "R4/R8 reset state", {27'd0, cs_n, sclk, done, cmd_ready, rd_valid}, 5'b10010);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         run_txn(v, VEC[v][35], int'(VEC[v][34:28]), VEC[v][27:4], int'(VEC[v][3:0]));
      end

      // R2 corner lengths
      reject(0);
      reject(65);
      reject(127);

      // R7 / R8 timeout on a target that never becomes ready
      for (int k = 0; k < 128; k++) tgt_tx[k] = 8'h80;
      tgt_tx[3] = 8'h40;
      rb0 = rd_cnt;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_read = 1'b1; cmd_len = 7'd4; cmd_addr = 24'h000F00;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done(seen, err);
      check(seen && err, "R7 timeout flags done and error", {30'd0, seen, err}, 3);
      @(negedge clk);
      tb0 = t_byte;
      check(cs_n == 1'b1, "R7 chip select released on timeout", cs_n, 1);
      check(tb0 > 4 && tb0 <= 4 + TMO / (16 * DIVH) + 3, "R7 poll bytes bounded by timeout",
            tb0, 4 + TMO / (16 * DIVH));
      check(rd_cnt == rb0 && rd_data == 8'h00, "R8 aborted read gives no data",
            rd_cnt - rb0, 0);

      // R5 recovery: a normal read works after the abort
      run_txn(9, 1'b1, 3, 24'h000004, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule